// File: doc/BRIEF.md
# SPI Slave Buffered Transfer Engine

This block is an SPI slave for a chip that keeps its transfer data in local buffers. While the chip select input is low, it shifts one byte at a time in from MOSI and out on MISO. Transmit bytes are read from a buffer port whose address is the running byte index. Received bytes are written to a second buffer port. Each direction has its own programmable byte limit. The clock polarity and phase come from a two-bit mode input, and a separate bit selects which end of the byte goes first.

A grant input is sampled when chip select falls. A granted transaction uses the buffers. Once the transmit limit is reached, the block sends a programmable over-read character and raises a sticky over-read flag. Once the receive limit is reached, it drops the extra received bytes and raises a sticky overflow flag. When chip select rises, it latches the exact transmitted and received byte counts and pulses an end strobe.

A transaction that is not granted sends a programmable default character on every byte. It writes nothing, and it leaves the counts and the flags unchanged. The SPI pins are synchronized into the system clock, so SCK must be slow compared with that clock.

Top module: `spi_slave_xfer`

## Requirements
- R1: `mode_i` bit 1 sets the idle SCK level, where 1 means idle high. `mode_i` bit 0 set to 0 samples MOSI on the edge leaving idle and changes MISO on the edge returning to idle. Set to 1, it changes MISO on the leaving edge and samples on the returning edge. With phase 0, the first bit appears on MISO once chip select falls.
- R2: With `lsb_first_i` at 0, bit 7 of each byte goes first in both directions. With it at 1, bit 0 goes first.
- R3: In a granted transaction, byte k on MISO for k below `max_tx_i` is the buffer value at `tx_addr_o` = k.
- R4: In a granted transaction, every byte after the first `max_tx_i` bytes is `orc_i`. Completing such a byte sets `overread_o`.
- R5: In a granted transaction, the first `max_rx_i` complete received bytes are written through `rx_we_o` to addresses 0, 1, 2 and onward. Later bytes are not written, and each one sets `overflow_o`.
- R6: A transaction with `grant_i` low when chip select falls sends `def_i` on every byte. It writes nothing, raises no end strobe, and leaves the counts and the flags unchanged.
- R7: A granted transaction produces exactly one single-cycle `end_o` pulse after chip select rises.
- R8: At the end strobe, `tx_count_o` equals min(full bytes, `max_tx_i`) and `rx_count_o` equals min(full bytes, `max_rx_i`). A trailing partial byte is not counted and not written.
- R9: Both counts read 0 from the start of a granted transaction until its end.
- R10: `miso_oe_o` is 0 while chip select is high and 1 while it is low.
- R11: The two flags stay set until cleared. Bit 0 of `status_clr_i` clears `overread_o` and bit 1 clears `overflow_o`, and each bit affects only its own flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| sck_i | input | 1 | SPI clock from master |
| csn_i | input | 1 | Chip select, active low |
| mosi_i | input | 1 | Serial data in |
| miso_o | output | 1 | Serial data out |
| miso_oe_o | output | 1 | Output enable for MISO pad |
| grant_i | input | 1 | Buffers owned by engine, sampled at select fall |
| mode_i | input | 2 | Bit 1 idle polarity, bit 0 phase |
| lsb_first_i | input | 1 | Bit order select |
| max_tx_i | input | 8 | Transmit byte limit |
| max_rx_i | input | 8 | Receive byte limit |
| orc_i | input | 8 | Filler sent after transmit limit |
| def_i | input | 8 | Filler sent when not granted |
| tx_addr_o | output | 8 | Transmit buffer read address |
| tx_data_i | input | 8 | Transmit buffer read data, same cycle |
| rx_we_o | output | 1 | Receive buffer write strobe |
| rx_addr_o | output | 8 | Receive buffer write address |
| rx_data_o | output | 8 | Receive buffer write data |
| tx_count_o | output | 8 | Bytes sent from buffer, last granted transaction |
| rx_count_o | output | 8 | Bytes stored, last granted transaction |
| overread_o | output | 1 | Sticky over-read flag |
| overflow_o | output | 1 | Sticky overflow flag |
| status_clr_i | input | 2 | Write-one-to-clear pulses for the flags |
| end_o | output | 1 | Granted transaction done |

## Verification
A wrong bit counter or a wrong edge decode shows up within the first byte: every later MISO byte is misaligned or bit-reversed, and the bytes written to the receive buffer no longer match MOSI. A wrong byte counter shows up at the limit. The over-read character appears one byte early or late, or a write lands at an address past the limit, and the latched counts disagree a few cycles after chip select rises. A grant latch that leaks between transactions shows up on the next ungranted transfer, as writes, an end pulse or changed counts.

// File: rtl/spis_pkg.sv
package spis_pkg;
  localparam int unsigned CLR_OVR_BIT = 0;
  localparam int unsigned CLR_OVF_BIT = 1;

  typedef struct packed {
    logic cpol;
    logic cpha;
  } spi_mode_t;
endpackage

// File: rtl/spis_sync.sv
module spis_sync #(
  parameter int unsigned WIDTH = 1,
  parameter int unsigned STAGES = 2,
  parameter logic [WIDTH-1:0] RST_VAL = '0
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [WIDTH-1:0] d_i,
  output logic [WIDTH-1:0] q_o
);
  logic [STAGES-1:0][WIDTH-1:0] stg_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) stg_q <= {STAGES{RST_VAL}};
    else         stg_q <= {stg_q[STAGES-2:0], d_i};
  end

  assign q_o = stg_q[STAGES-1];
endmodule

// File: rtl/spis_front.sv
module spis_front #(
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic sck_i,
  input  logic csn_i,
  input  logic mosi_i,
  input  spis_pkg::spi_mode_t mode_i,
  output logic active_o,
  output logic start_o,
  output logic stop_o,
  output logic sample_o,
  output logic shift_o,
  output logic mosi_o
);
  logic csn_s, sck_s, mosi_s;
  logic csn_q, sck_q;
  logic sck_edge, lead, trail, run;

  spis_sync #(.WIDTH(3), .STAGES(SYNC_STAGES), .RST_VAL(3'b100)) u_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   ({csn_i, sck_i, mosi_i}),
    .q_o   ({csn_s, sck_s, mosi_s})
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      csn_q <= 1'b1;
      sck_q <= 1'b0;
    end else begin
      csn_q <= csn_s;
      sck_q <= sck_s;
    end
  end

  assign sck_edge = sck_s ^ sck_q;
  assign lead     = sck_edge & (sck_q == mode_i.cpol);
  assign trail    = sck_edge & (sck_s == mode_i.cpol);
  assign start_o  = csn_q & ~csn_s;
  assign stop_o   = ~csn_q & csn_s;
  assign active_o = ~csn_s;
  // edges during the select-fall cycle are ignored
  assign run      = active_o & ~start_o;
  assign sample_o = run & (mode_i.cpha ? trail : lead);
  assign shift_o  = run & (mode_i.cpha ? lead : trail);
  assign mosi_o   = mosi_s;
endmodule

// File: rtl/spis_tx.sv
module spis_tx #(
  parameter int unsigned DW = 8,
  parameter int unsigned LW = 8,
  localparam int unsigned BW = $clog2(DW)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          start_i,
  input  logic          shift_i,
  input  logic          byte_done_i,
  input  logic          gnt_i,
  input  logic          cpha_i,
  input  logic          lsb_first_i,
  input  logic [LW-1:0] max_i,
  input  logic [DW-1:0] orc_i,
  input  logic [DW-1:0] def_i,
  output logic [LW-1:0] addr_o,
  input  logic [DW-1:0] data_i,
  output logic          miso_o,
  output logic [LW-1:0] cnt_o,
  output logic          ovr_set_o
);
  logic [LW-1:0] cnt_q, cnt_eff;
  logic [BW-1:0] drv_q, drv_eff, bit_idx;
  logic [DW-1:0] hold_q, byte_sel, cur;
  logic          miso_q, drive, in_buf;

  assign drive    = (start_i & ~cpha_i) | shift_i;
  assign cnt_eff  = start_i ? '0 : cnt_q;
  assign drv_eff  = start_i ? '0 : drv_q;
  assign in_buf   = cnt_eff < max_i;
  assign addr_o   = cnt_eff;

  always_comb begin
    if (!gnt_i)      byte_sel = def_i;
    else if (in_buf) byte_sel = data_i;
    else             byte_sel = orc_i;
  end

  assign cur     = (drv_eff == '0) ? byte_sel : hold_q;
  assign bit_idx = lsb_first_i ? drv_eff : BW'(DW - 1) - drv_eff;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q  <= '0;
      drv_q  <= '0;
      hold_q <= '0;
      miso_q <= 1'b0;
    end else begin
      if (start_i) begin
        cnt_q <= '0;
        drv_q <= '0;
      end
      if (drive) begin
        if (drv_eff == '0) hold_q <= byte_sel;
        miso_q <= cur[bit_idx];
        drv_q  <= (drv_eff == BW'(DW - 1)) ? '0 : drv_eff + 1'b1;
      end
      if (byte_done_i && gnt_i && in_buf) cnt_q <= cnt_q + 1'b1;
    end
  end

  assign ovr_set_o = byte_done_i & gnt_i & ~in_buf;
  assign miso_o    = miso_q;
  assign cnt_o     = cnt_q;

  a_r3_tx_count_step: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cnt_q != $past(cnt_q)) |-> (cnt_q == $past(cnt_q) + 1'b1 || cnt_q == '0));
endmodule

// File: rtl/spis_rx.sv
module spis_rx #(
  parameter int unsigned DW = 8,
  parameter int unsigned LW = 8,
  localparam int unsigned BW = $clog2(DW)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          start_i,
  input  logic          sample_i,
  input  logic          mosi_i,
  input  logic          gnt_i,
  input  logic          lsb_first_i,
  input  logic [LW-1:0] max_i,
  output logic          byte_done_o,
  output logic          we_o,
  output logic [LW-1:0] addr_o,
  output logic [DW-1:0] data_o,
  output logic [LW-1:0] cnt_o,
  output logic          ovf_set_o
);
  logic [BW-1:0] bit_q;
  logic [DW-1:0] sr_q, sr_nxt, data_q;
  logic [LW-1:0] cnt_q, addr_q;
  logic          we_q, room;

  assign byte_done_o = sample_i & (bit_q == BW'(DW - 1));
  assign sr_nxt = lsb_first_i ? {mosi_i, sr_q[DW-1:1]} : {sr_q[DW-2:0], mosi_i};
  assign room   = cnt_q < max_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      bit_q  <= '0;
      sr_q   <= '0;
      cnt_q  <= '0;
      we_q   <= 1'b0;
      addr_q <= '0;
      data_q <= '0;
    end else begin
      we_q <= 1'b0;
      if (start_i) begin
        bit_q <= '0;
        cnt_q <= '0;
      end
      if (sample_i) begin
        sr_q  <= sr_nxt;
        bit_q <= byte_done_o ? '0 : bit_q + 1'b1;
      end
      if (byte_done_o && gnt_i && room) begin
        we_q   <= 1'b1;
        addr_q <= cnt_q;
        data_q <= sr_nxt;
        cnt_q  <= cnt_q + 1'b1;
      end
    end
  end

  assign ovf_set_o = byte_done_o & gnt_i & ~room;
  assign we_o      = we_q;
  assign addr_o    = addr_q;
  assign data_o    = data_q;
  assign cnt_o     = cnt_q;

  a_r5_write_below_count: assert property (@(posedge clk_i) disable iff (!rst_ni)
    we_q |-> (addr_q < cnt_q));
endmodule

// File: rtl/spi_slave_xfer.sv
module spi_slave_xfer #(
  parameter int unsigned DW = 8,
  parameter int unsigned LW = 8,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          sck_i,
  input  logic          csn_i,
  input  logic          mosi_i,
  output logic          miso_o,
  output logic          miso_oe_o,
  input  logic          grant_i,
  input  logic [1:0]    mode_i,
  input  logic          lsb_first_i,
  input  logic [LW-1:0] max_tx_i,
  input  logic [LW-1:0] max_rx_i,
  input  logic [DW-1:0] orc_i,
  input  logic [DW-1:0] def_i,
  output logic [LW-1:0] tx_addr_o,
  input  logic [DW-1:0] tx_data_i,
  output logic          rx_we_o,
  output logic [LW-1:0] rx_addr_o,
  output logic [DW-1:0] rx_data_o,
  output logic [LW-1:0] tx_count_o,
  output logic [LW-1:0] rx_count_o,
  output logic          overread_o,
  output logic          overflow_o,
  input  logic [1:0]    status_clr_i,
  output logic          end_o
);
  import spis_pkg::*;

  spi_mode_t     mode;
  logic          active, start, stop, sample, shift, mosi_s, byte_done;
  logic          gnt_q, gnt_eff, end_q, ovr_q, ovf_q, ovr_set, ovf_set;
  logic [LW-1:0] tx_cnt, rx_cnt, tx_cnt_q, rx_cnt_q;

  assign mode = spi_mode_t'(mode_i);

  spis_front #(.SYNC_STAGES(SYNC_STAGES)) u_front (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .sck_i   (sck_i),
    .csn_i   (csn_i),
    .mosi_i  (mosi_i),
    .mode_i  (mode),
    .active_o(active),
    .start_o (start),
    .stop_o  (stop),
    .sample_o(sample),
    .shift_o (shift),
    .mosi_o  (mosi_s)
  );

  assign gnt_eff = start ? grant_i : gnt_q;

  spis_tx #(.DW(DW), .LW(LW)) u_tx (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .start_i    (start),
    .shift_i    (shift),
    .byte_done_i(byte_done),
    .gnt_i      (gnt_eff),
    .cpha_i     (mode.cpha),
    .lsb_first_i(lsb_first_i),
    .max_i      (max_tx_i),
    .orc_i      (orc_i),
    .def_i      (def_i),
    .addr_o     (tx_addr_o),
    .data_i     (tx_data_i),
    .miso_o     (miso_o),
    .cnt_o      (tx_cnt),
    .ovr_set_o  (ovr_set)
  );

  spis_rx #(.DW(DW), .LW(LW)) u_rx (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .start_i    (start),
    .sample_i   (sample),
    .mosi_i     (mosi_s),
    .gnt_i      (gnt_eff),
    .lsb_first_i(lsb_first_i),
    .max_i      (max_rx_i),
    .byte_done_o(byte_done),
    .we_o       (rx_we_o),
    .addr_o     (rx_addr_o),
    .data_o     (rx_data_o),
    .cnt_o      (rx_cnt),
    .ovf_set_o  (ovf_set)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      gnt_q    <= 1'b0;
      end_q    <= 1'b0;
      tx_cnt_q <= '0;
      rx_cnt_q <= '0;
      ovr_q    <= 1'b0;
      ovf_q    <= 1'b0;
    end else begin
      end_q <= stop & gnt_q;
      if (start) gnt_q <= grant_i;
      else if (stop) gnt_q <= 1'b0;
      if (start && grant_i) begin
        tx_cnt_q <= '0;
        rx_cnt_q <= '0;
      end else if (stop && gnt_q) begin
        tx_cnt_q <= tx_cnt;
        rx_cnt_q <= rx_cnt;
      end
      // set wins over a same-cycle clear
      ovr_q <= ovr_set | (ovr_q & ~status_clr_i[CLR_OVR_BIT]);
      ovf_q <= ovf_set | (ovf_q & ~status_clr_i[CLR_OVF_BIT]);
    end
  end

  assign miso_oe_o  = active;
  assign end_o      = end_q;
  assign tx_count_o = tx_cnt_q;
  assign rx_count_o = rx_cnt_q;
  assign overread_o = ovr_q;
  assign overflow_o = ovf_q;

  a_r7_end_single: assert property (@(posedge clk_i) disable iff (!rst_ni)
    end_q |=> !end_q);
  a_r6_end_needs_grant: assert property (@(posedge clk_i) disable iff (!rst_ni)
    end_q |-> $past(gnt_q));
  a_r10_oe_off_at_end: assert property (@(posedge clk_i) disable iff (!rst_ni)
    end_q |-> !miso_oe_o);
  a_r11_overread_sticky: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ovr_q && !status_clr_i[CLR_OVR_BIT]) |=> ovr_q);
  a_r11_overflow_sticky: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ovf_q && !status_clr_i[CLR_OVF_BIT]) |=> ovf_q);
endmodule

// File: tb/spi_slave_xfer_bench.sv
module spi_slave_xfer_bench;
  localparam int CLK_P = 10;
  localparam int H = 8;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       sck = 1'b0, csn = 1'b1, mosi = 1'b0;
  logic       miso, miso_oe, grant = 1'b0, lsb = 1'b0;
  logic [1:0] mode = 2'b00, clr = 2'b00;
  logic [7:0] max_tx = 8'd0, max_rx = 8'd0, orc = 8'd0, def = 8'd0;
  logic [7:0] tx_addr, tx_data, rx_addr, rx_data, tx_count, rx_count;
  logic       rx_we, ovr, ovf, end_p;

  logic [7:0] tx_mem [256];
  logic [7:0] rx_mem [256];
  logic [7:0] mo [32];
  logic [7:0] mi [32];
  int wr_cnt = 0, end_cnt = 0, errors = 0, checks = 0;
  bit done = 0;

  always #(CLK_P/2) clk = ~clk;
  assign tx_data = tx_mem[tx_addr];

  spi_slave_xfer u_spi_slave_xfer (
    .clk_i(clk), .rst_ni(rst_n), .sck_i(sck), .csn_i(csn), .mosi_i(mosi),
    .miso_o(miso), .miso_oe_o(miso_oe), .grant_i(grant), .mode_i(mode),
    .lsb_first_i(lsb), .max_tx_i(max_tx), .max_rx_i(max_rx), .orc_i(orc),
    .def_i(def), .tx_addr_o(tx_addr), .tx_data_i(tx_data), .rx_we_o(rx_we),
    .rx_addr_o(rx_addr), .rx_data_o(rx_data), .tx_count_o(tx_count),
    .rx_count_o(rx_count), .overread_o(ovr), .overflow_o(ovf),
    .status_clr_i(clr), .end_o(end_p)
  );

  always @(negedge clk) begin
    if (rx_we) begin
      rx_mem[rx_addr] <= rx_data;
      wr_cnt <= wr_cnt + 1;
    end
    if (end_p) end_cnt <= end_cnt + 1;
  end

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s act=%0d exp=%0d", tag, act, exp);
    end
  endtask

  function automatic int mn(input int a, input int b);
    return (a < b) ? a : b;
  endfunction

  task automatic clear_flags(input logic [1:0] m);
    clr = m;
    tick(1);
    clr = 2'b00;
    tick(2);
  endtask

  task automatic xfer(input int nbits, input logic g);
    logic cpol, cpha;
    cpol = mode[1];
    cpha = mode[0];
    grant = g;
    sck = cpol;
    tick(6);
    csn = 1'b0;
    for (int i = 0; i < nbits; i++) begin
      int byt = i / 8;
      int idx = lsb ? (i % 8) : 7 - (i % 8);
      if (!cpha) begin
        mosi = mo[byt][idx];
        tick(H);
        mi[byt][idx] = miso;
        sck = ~cpol;
        tick(H);
        sck = cpol;
      end else begin
        tick(H);
        sck = ~cpol;
        mosi = mo[byt][idx];
        tick(H);
        mi[byt][idx] = miso;
        sck = cpol;
      end
      if (i == 3) begin
        chk("R10 oe active", int'(miso_oe), 1);
        if (g) begin
          chk("R9 tx count cleared", int'(tx_count), 0);
          chk("R9 rx count cleared", int'(rx_count), 0);
        end
      end
    end
    tick(H);
    csn = 1'b1;
    tick(8);
    chk("R10 oe idle", int'(miso_oe), 0);
  endtask

  task automatic run_case(input int nbits, input logic g);
    int full, wr0, end0, ptx, prx, exp_wr;
    full = nbits / 8;
    for (int k = 0; k < 32; k++) begin
      mo[k] = 8'($urandom);
      mi[k] = 8'h00;
      rx_mem[k] = ~mo[k];
    end
    for (int k = 0; k < 16; k++) tx_mem[k] = 8'($urandom);
    clear_flags(2'b11);
    wr0 = wr_cnt; end0 = end_cnt;
    ptx = int'(tx_count); prx = int'(rx_count);
    xfer(nbits, g);
    for (int k = 0; k < full; k++) begin
      if (!g)                 chk("R6 default byte", int'(mi[k]), int'(def));
      else if (k < int'(max_tx)) chk("R1 R2 R3 buffer byte", int'(mi[k]), int'(tx_mem[k]));
      else                    chk("R4 over-read byte", int'(mi[k]), int'(orc));
    end
    exp_wr = g ? mn(full, int'(max_rx)) : 0;
    chk("R5 R6 write count", wr_cnt - wr0, exp_wr);
    for (int k = 0; k < exp_wr; k++)
      chk("R1 R2 R5 stored byte", int'(rx_mem[k]), int'(mo[k]));
    chk("R4 overread flag", int'(ovr), int'(g && full > int'(max_tx)));
    chk("R5 overflow flag", int'(ovf), int'(g && full > int'(max_rx)));
    chk("R7 end pulses", end_cnt - end0, int'(g));
    if (g) begin
      chk("R8 tx count", int'(tx_count), mn(full, int'(max_tx)));
      chk("R8 rx count", int'(rx_count), mn(full, int'(max_rx)));
    end else begin
      chk("R6 tx count kept", int'(tx_count), ptx);
      chk("R6 rx count kept", int'(rx_count), prx);
    end
  endtask

  initial begin
    int unsigned seed_v;
    seed_v = $urandom(32'd4242);
    for (int k = 0; k < 256; k++) begin
      tx_mem[k] = 8'h00;
      rx_mem[k] = 8'h00;
    end
    tick(3);
    rst_n = 1'b1;
    tick(3);
    chk("R10 reset oe", int'(miso_oe), 0);
    chk("R7 reset end", int'(end_p), 0);
    chk("R8 reset tx count", int'(tx_count), 0);
    chk("R8 reset rx count", int'(rx_count), 0);
    chk("R11 reset flags", int'({ovr, ovf}), 0);
    chk("R5 reset write", int'(rx_we), 0);

    // directed: exact fit, mode 0, msb first
    mode = 2'd0; lsb = 1'b0; max_tx = 8'd3; max_rx = 8'd3; orc = 8'hA5; def = 8'h3C;
    run_case(24, 1'b1);
    // directed: both limits exceeded, mode 3, lsb first
    mode = 2'd3; lsb = 1'b1; max_tx = 8'd2; max_rx = 8'd2;
    run_case(32, 1'b1);
    clear_flags(2'b01);
    chk("R11 clear overread only", int'(ovr), 0);
    chk("R11 overflow kept", int'(ovf), 1);
    clear_flags(2'b10);
    chk("R11 clear overflow", int'(ovf), 0);
    // directed: partial final byte, mode 1
    mode = 2'd1; lsb = 1'b0; max_tx = 8'd4; max_rx = 8'd4;
    run_case(21, 1'b1);
    // directed: not granted, mode 2
    mode = 2'd2; lsb = 1'b1;
    run_case(16, 1'b0);
    // directed: zero limits
    mode = 2'd0; lsb = 1'b0; max_tx = 8'd0; max_rx = 8'd0;
    run_case(8, 1'b1);

    for (int t = 0; t < 20; t++) begin
      mode   = 2'($urandom_range(0, 3));
      lsb    = 1'($urandom_range(0, 1));
      max_tx = 8'($urandom_range(0, 6));
      max_rx = 8'($urandom_range(0, 6));
      orc    = 8'($urandom);
      def    = 8'($urandom);
      run_case($urandom_range(0, 8) * 8 + $urandom_range(0, 7),
               ($urandom_range(0, 9) != 0));
    end

    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog expired act=0 exp=1");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule